// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Program Engine

This block is the slave-side program path of a serial EEPROM that talks over a select line, a serial clock and a serial data input, and answers on a data output that can be released. While selected, it collects an instruction frame. The frame holds a start bit, a two-bit opcode and an address, and for a store a data word as well. When the select line drops after a frame that is complete and valid, the block runs a program cycle that needs no clocking. The cycle is timed in system clocks against an internal register array.

The cycle empties the target word to all ones before it stores the new value. This makes a separate erase pass unnecessary. While a cycle is in progress, a host that selects the device sees a low level on the output. When the cycle is over it sees a high level. When the device is deselected, the output is not driven.

The select, serial clock and data pins are brought into the system clock domain through synchronizer chains, and edges are found on the synchronized copies. A plain read port on the array lets the surrounding device logic see the stored words.

Top module: `sw3_eeprom_prog`

## Requirements
- R1: After reset every array word reads all ones, `do_oe` is 0 and no cycle is running.
- R2: A frame starts with the first serial-clock rise that samples data 1, and any 0 bits before that are skipped. After it come 2 opcode bits, then AW address bits MSB first, then for a store DW data bits MSB first. Opcode 01 is a store and opcode 11 is an erase.
- R3: A program cycle starts only on the falling edge of the select line after a complete store or erase frame. With the default two synchronizer stages, the output reads busy for exactly TPROG system clocks. The first of these follows the third rising clock edge after `cs_i` is first sampled low.
- R4: A store sets the addressed word to all ones when the cycle begins. It writes the shifted data word when the cycle ends.
- R5: An erase leaves every bit of the addressed word at 1, and serial bits beyond the address are ignored.
- R6: `do_oe` follows the synchronized select. While it is 1, `do_o` is 0 during a cycle and 1 otherwise.
- R7: A selection that begins while a cycle is running is ignored completely, even if the cycle ends before that selection is released.
- R8: When the select line drops before a store or erase frame is complete, the array is left unchanged. Opcodes 00 and 10 leave it unchanged as well.
- R9: A selection whose preceding deselect lasted fewer than CSMIN synchronized clocks is ignored.
- R10: A program cycle runs to completion with the serial clock held still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Device select, active high |
| sk_i | input | 1 | Serial clock, bits taken on its rise |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Status out: 0 busy, 1 ready |
| do_oe | output | 1 | Drive enable for `do_o`, 0 means high impedance |
| rd_addr | input | AW | Array read address |
| rd_data | output | DW | Array word at `rd_addr` |

## Verification
Two things can fall in the same cycle: a new selection arriving, and a program cycle that is still running. The case is provoked by releasing a store, waiting past the deselect minimum, and then shifting a complete store frame to another address while the first cycle is still busy. That frame lasts longer than the cycle, so the busy flag is already clear when the second release arrives. The scoreboard judges the result: it expects the first address to hold its data and the second to stay all ones.

// File: rtl/sw3_pkg.sv
package sw3_pkg;
   typedef enum logic [1:0] {
      OPC_X00   = 2'b00,
      OPC_STORE = 2'b01,
      OPC_X10   = 2'b10,
      OPC_ERASE = 2'b11
   } sw3_opc_e;
endpackage

// File: rtl/sw3_sync.sv
module sw3_sync #(
   parameter int N      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sw3_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < N; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/sw3_rx.sv
module sw3_rx
   import sw3_pkg::*;
#(
   parameter int AW = 6,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_s,
   input  logic          cs_rise,
   input  logic          sk_rise,
   input  logic          di_s,
   input  logic          busy,
   input  logic          desel_ok,
   output logic          frame_ok,
   output logic [1:0]    opc,
   output logic [AW-1:0] addr,
   output logic [DW-1:0] data
);
   localparam int TOT = 2 + AW + DW;
   localparam int CW  = $clog2(TOT + 1);

   logic          started;
   logic          ign;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started <= 1'b0;
         ign     <= 1'b0;
         cnt     <= '0;
         opc     <= '0;
         addr    <= '0;
         data    <= '0;
      end else if (cs_rise) begin
         started <= 1'b0;
         cnt     <= '0;
         ign     <= busy | ~desel_ok;
      end else if (cs_s && sk_rise && !ign) begin
         if (!started) begin
            started <= di_s;
         end else if (cnt < CW'(TOT)) begin
            if (cnt < CW'(2))           opc  <= {opc[0], di_s};
            else if (cnt < CW'(2 + AW)) addr <= {addr[AW-2:0], di_s};
            else                        data <= {data[DW-2:0], di_s};
            cnt <= cnt + CW'(1);
         end
      end
   end

   assign frame_ok = started && !ign &&
                     ((opc == OPC_STORE && cnt == CW'(TOT)) ||
                      (opc == OPC_ERASE && cnt >= CW'(2 + AW)));

   // R2
   bit_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sk_rise && !cs_rise) |=> $stable(cnt));
endmodule

// File: rtl/sw3_ctl.sv
module sw3_ctl
   import sw3_pkg::*;
#(
   parameter int AW    = 6,
   parameter int DW    = 16,
   parameter int TPROG = 40,
   parameter int CSMIN = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_s,
   input  logic          cs_fall,
   input  logic          frame_ok,
   input  logic [1:0]    opc,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] data,
   output logic          busy,
   output logic          desel_ok,
   output logic          clr_en,
   output logic          wr_en,
   output logic [AW-1:0] m_addr,
   output logic [DW-1:0] m_data
);
   localparam int TW = $clog2(TPROG);
   localparam int LW = $clog2(CSMIN + 1);

   logic [TW-1:0] tmr;
   logic [LW-1:0] lowcnt;
   logic [1:0]    opc_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;
   logic          launch;

   assign launch = cs_fall && frame_ok && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         tmr    <= '0;
         opc_q  <= '0;
         addr_q <= '0;
         data_q <= '0;
      end else if (launch) begin
         busy   <= 1'b1;
         tmr    <= TW'(TPROG - 1);
         opc_q  <= opc;
         addr_q <= addr;
         data_q <= data;
      end else if (busy) begin
         if (tmr == '0) busy <= 1'b0;
         else           tmr  <= tmr - TW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              lowcnt <= LW'(CSMIN);
      else if (cs_fall)                        lowcnt <= LW'(1);
      else if (!cs_s && lowcnt < LW'(CSMIN))   lowcnt <= lowcnt + LW'(1);
   end

   assign desel_ok = (lowcnt >= LW'(CSMIN));
   assign clr_en   = launch;
   assign wr_en    = busy && (tmr == '0) && (opc_q == OPC_STORE);
   assign m_addr   = busy ? addr_q : addr;
   assign m_data   = data_q;

   // R3
   start_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cs_fall));

   // R7
   cmd_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(addr_q) && $stable(data_q) && $stable(opc_q)));
endmodule

// File: rtl/sw3_mem.sv
module sw3_mem #(
   parameter int AW = 6,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_en,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (clr_en) begin
         mem[addr] <= '1;
      end else if (wr_en) begin
         mem[addr] <= wdata;
      end
   end

   assign rd_data = mem[rd_addr];

   // R4
   clear_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |=> (mem[$past(addr)] == {DW{1'b1}}));
endmodule

// File: rtl/sw3_eeprom_prog.sv
module sw3_eeprom_prog #(
   parameter int AW     = 6,
   parameter int DW     = 16,
   parameter int TPROG  = 40,
   parameter int CSMIN  = 4,
   parameter int STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_i,
   input  logic          sk_i,
   input  logic          di_i,
   output logic          do_o,
   output logic          do_oe,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);
   if (DW != 8 && DW != 16) begin : g_bad_dw
      $error("sw3_eeprom_prog: DW must be 8 or 16");
   end
   if (AW < 2) begin : g_bad_aw
      $error("sw3_eeprom_prog: AW must be at least 2");
   end
   if (TPROG < 2 || CSMIN < 1) begin : g_bad_time
      $error("sw3_eeprom_prog: TPROG >= 2 and CSMIN >= 1 required");
   end

   logic [2:0]    pin_s;
   logic          cs_s, sk_s, di_s, cs_q, sk_q;
   logic          cs_rise, cs_fall, sk_rise;
   logic          busy, desel_ok, frame_ok, clr_en, wr_en;
   logic [1:0]    opc;
   logic [AW-1:0] rx_addr, m_addr;
   logic [DW-1:0] rx_data, m_data;

   sw3_sync #(.N(3), .STAGES(STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cs_i, sk_i, di_i}), .q(pin_s));

   assign {cs_s, sk_s, di_s} = pin_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q <= 1'b0;
         sk_q <= 1'b0;
      end else begin
         cs_q <= cs_s;
         sk_q <= sk_s;
      end
   end

   assign cs_rise = cs_s & ~cs_q;
   assign cs_fall = ~cs_s & cs_q;
   assign sk_rise = sk_s & ~sk_q;

   sw3_rx #(.AW(AW), .DW(DW)) u_rx (
      .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_rise(cs_rise),
      .sk_rise(sk_rise), .di_s(di_s), .busy(busy), .desel_ok(desel_ok),
      .frame_ok(frame_ok), .opc(opc), .addr(rx_addr), .data(rx_data));

   sw3_ctl #(.AW(AW), .DW(DW), .TPROG(TPROG), .CSMIN(CSMIN)) u_ctl (
      .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_fall(cs_fall),
      .frame_ok(frame_ok), .opc(opc), .addr(rx_addr), .data(rx_data),
      .busy(busy), .desel_ok(desel_ok), .clr_en(clr_en), .wr_en(wr_en),
      .m_addr(m_addr), .m_data(m_data));

   sw3_mem #(.AW(AW), .DW(DW)) u_mem (
      .clk(clk), .rst_n(rst_n), .clr_en(clr_en), .wr_en(wr_en),
      .addr(m_addr), .wdata(m_data), .rd_addr(rd_addr), .rd_data(rd_data));

   assign do_oe = cs_s;
   assign do_o  = ~busy;
endmodule

// File: tb/sim_sw3_eeprom_prog.sv
module sim_sw3_eeprom_prog;
   localparam int CLK_NS = 10;
   localparam int AW     = 6;
   localparam int DW     = 16;
   localparam int TPROG  = 40;
   localparam int CSMIN  = 4;

   logic          clk = 1'b0;
   logic          rst_n, cs_i, sk_i, di_i;
   logic          do_o, do_oe;
   logic [AW-1:0] rd_addr;
   logic [DW-1:0] rd_data;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   typedef struct {
      int            a;
      logic [DW-1:0] exp;
      string         tag;
   } sb_item_t;

   sb_item_t sb_q[$];
   event     chk_ev;

   always #(CLK_NS / 2) clk = ~clk;

   sw3_eeprom_prog #(.AW(AW), .DW(DW), .TPROG(TPROG), .CSMIN(CSMIN)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sk_i(sk_i), .di_i(di_i),
      .do_o(do_o), .do_oe(do_oe), .rd_addr(rd_addr), .rd_data(rd_data));

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: pops expected array words and compares them
   initial begin
      rd_addr = '0;
      forever begin
         @(chk_ev);
         while (sb_q.size() > 0) begin
            rd_addr = AW'(sb_q[0].a);
            #1;
            check(32'(rd_data), 32'(sb_q[0].exp), sb_q[0].tag);
            void'(sb_q.pop_front());
         end
      end
   end

   task automatic expect_word(input int a, input logic [DW-1:0] v, input string tag);
      sb_item_t it;
      it.a = a; it.exp = v; it.tag = tag;
      sb_q.push_back(it);
      ->chk_ev;
      wait (sb_q.size() == 0);
      #1;
   endtask

   task automatic sk_bit(input logic b);
      di_i = b;
      repeat (3) @(negedge clk);
      sk_i = 1'b1;
      repeat (3) @(negedge clk);
      sk_i = 1'b0;
   endtask

   task automatic frame(input logic [1:0] opc, input int a, input logic [DW-1:0] d,
                        input int nd, input int nlead);
      cs_i = 1'b1;
      repeat (3) @(negedge clk);
      for (int i = 0; i < nlead; i++) sk_bit(1'b0);
      sk_bit(1'b1);
      for (int i = 1; i >= 0; i--) sk_bit(opc[i]);
      for (int i = AW - 1; i >= 0; i--) sk_bit(a[i]);
      for (int i = DW - 1; i >= DW - nd; i--) sk_bit(d[i]);
   endtask

   task automatic release_plain();
      cs_i = 1'b0;
      repeat (TPROG + 20) @(negedge clk);
   endtask

   // release, then poll status with exact cycle expectations
   task automatic release_timed(input int a);
      cs_i = 1'b0;
      for (int j = 1; j <= TPROG + 3; j++) begin
         @(negedge clk);
         if (j == 5) expect_word(a, '1, "R4 clear at cycle start");
         if (j == 8) cs_i = 1'b1;
         if (j == TPROG + 2) begin
            check(32'(do_oe), 32'd1, "R6 driven while selected");
            check(32'(do_o), 32'd0, "R3 busy on last cycle clock");
         end
         if (j == TPROG + 3) check(32'(do_o), 32'd1, "R10 ready with SK idle");
      end
      cs_i = 1'b0;
      repeat (10) @(negedge clk);
   endtask

   initial begin
      rst_n = 1'b0; cs_i = 1'b0; sk_i = 1'b0; di_i = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      check(32'(do_oe), 32'd0, "R1 output released");
      expect_word(0, '1, "R1 word 0");
      expect_word(63, '1, "R1 last word");

      // R6 idle select shows ready, deselect releases
      cs_i = 1'b1;
      repeat (4) @(negedge clk);
      check(32'(do_oe), 32'd1, "R6 oe when selected");
      check(32'(do_o), 32'd1, "R6 ready when idle");
      cs_i = 1'b0;
      repeat (10) @(negedge clk);
      check(32'(do_oe), 32'd0, "R6 oe released");

      // R2 R3 R4 store with exact timing
      frame(2'b01, 5, 16'hA5C3, DW, 0);
      release_timed(5);
      expect_word(5, 16'hA5C3, "R2 R4 stored word");

      // R2 top address, neighbour untouched
      frame(2'b01, 63, 16'h8001, DW, 0);
      release_plain();
      expect_word(63, 16'h8001, "R2 top address");
      expect_word(62, '1, "R2 neighbour");

      // R2 leading zeros before start bit
      frame(2'b01, 9, 16'h00F0, DW, 2);
      release_plain();
      expect_word(9, 16'h00F0, "R2 leading zeros");

      // R5 erase, timed
      frame(2'b11, 5, '0, 0, 0);
      release_timed(5);
      expect_word(5, '1, "R5 erased");

      // R5 erase with trailing bits
      frame(2'b01, 62, 16'h1234, DW, 0);
      release_plain();
      expect_word(62, 16'h1234, "R5 pre-store");
      frame(2'b11, 62, 16'h0000, DW, 0);
      release_plain();
      expect_word(62, '1, "R5 erase extra bits");

      // R7 full frame during a running cycle
      frame(2'b01, 10, 16'hABCD, DW, 0);
      cs_i = 1'b0;
      repeat (10) @(negedge clk);
      frame(2'b01, 11, 16'h0000, DW, 0);
      release_plain();
      expect_word(10, 16'hABCD, "R7 first store");
      expect_word(11, '1, "R7 ignored store");

      // R8 incomplete frame and non-program opcodes
      frame(2'b01, 12, 16'h0000, 4, 0);
      release_plain();
      expect_word(12, '1, "R8 truncated store");
      frame(2'b01, 13, 16'h0000, DW, 0);
      release_plain();
      frame(2'b10, 13, 16'hFFFF, DW, 0);
      release_plain();
      expect_word(13, 16'h0000, "R8 opcode 10");
      frame(2'b00, 13, 16'hFFFF, DW, 0);
      release_plain();
      expect_word(13, 16'h0000, "R8 opcode 00");

      // R9 short deselect before selection
      cs_i = 1'b1;
      repeat (3) @(negedge clk);
      cs_i = 1'b0;
      repeat (2) @(negedge clk);
      frame(2'b01, 14, 16'h5555, DW, 0);
      release_plain();
      expect_word(14, '1, "R9 short deselect ignored");
      frame(2'b01, 14, 16'h5555, DW, 0);
      release_plain();
      expect_word(14, 16'h5555, "R9 normal deselect accepted");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL R3 watchdog: got hang expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule